// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sequences the repeated attempts of one DisplayPort AUX transaction and decides when to stop. A requester starts it with the direction and the requested byte count. The controller then starts a lower-level transfer engine once per attempt. Each attempt returns an outcome class, and a reply code and a count of returned bytes when the outcome is a success. The controller classifies each result and keeps its own counter for each kind of retry. It may insert a wait, timed from a free-running one-microsecond tick, before the next attempt. When it stops, it reports a single pass or fail.

Defers are handled by two rules together. A native defer may end the transaction only when the defer count has reached its limit and the accumulated defer time has reached its limit as well. A timeout that arrives after any defer has been seen is treated as one more defer, not as a timeout.

Top module: `auxr_retry_ctrl`

## Requirements
- R1: Each request launches the engine at most MAX_ATTEMPTS times (7 by default). When a retried attempt leaves no attempt left, the request ends in failure after that attempt's wait.
- R2: A success result (result code 0) with reply code 0 (ACK) ends the request in pass at once if the request is a write, or if it is a read whose returned byte count equals the requested length.
- R3: An ACK on a read that returns fewer bytes than requested increments the short-read counter. The request fails when that counter reaches 7. Otherwise it waits 300 us and retries.
- R4: The request fails at once, with no further launch, on any of these: result 3 (hot-plug lost), result 4 (engine could not be acquired), results 5 to 7 (unknown), or, on a success result, reply 1 (native NACK), reply 6 (hot-plug lost) or reply 7 (unknown).
- R5: Result 2 (invalid reply) increments the invalid counter. The request fails when that counter reaches 2. Otherwise it waits 400 us and retries.
- R6: Result 1 (timeout), when no defer has been seen in this request, increments the timeout counter. The request fails when that counter reaches 3. Otherwise it retries with no wait.
- R7: Every success result, whatever its reply code, clears the timeout counter and the invalid counter.
- R8: Reply 2 (native defer) increments the defer counter and adds poll_period_ms to the defer time. Reply 2 and reply 4 (I2C defer from the sink) both mark a defer as seen. After reply 2, reply 3 or reply 4, the request fails only if the defer count is at least DEFER_LIMIT (7 by default) and the defer time is at least 50 ms. Otherwise, after reply 2 or reply 4, it waits defer_delay_ms and adds that delay to the defer time.
- R9: A timeout after a defer has been seen increments the defer counter instead of the timeout counter. The request fails when the defer counter reaches DEFER_LIMIT. Otherwise it waits defer_delay_ms, skipping the wait when the delay is zero, and retries.
- R10: Reply 5 (I2C defer from the downstream bus) clears the defer counter and increments its own counter. The request fails when its own counter reaches 7. Otherwise it retries with no wait.
- R11: Reply 3 (I2C NACK) changes no counter and inserts no wait. It retries unless the defer exit rule of R8 holds.
- R12: req_busy is high from the cycle after req_start until req_done. req_done is a one-cycle pulse, and req_pass is valid with it. eng_start is a one-cycle pulse per attempt and appears only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| req_start | input | 1 | Start a transaction (sampled while idle) |
| req_is_write | input | 1 | Transaction is a write |
| req_len | input | LEN_W | Requested byte count |
| defer_delay_ms | input | DLY_W | Delay inserted after a defer, in ms |
| poll_period_ms | input | DLY_W | Polling period charged per native defer, in ms |
| req_busy | output | 1 | Transaction in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_pass | output | 1 | Outcome, valid with req_done |
| eng_start | output | 1 | Launch one engine attempt |
| eng_done | input | 1 | Engine attempt finished |
| eng_result | input | 3 | Outcome class of the attempt |
| eng_reply | input | 3 | Reply code on a success result |
| eng_rd_count | input | LEN_W | Bytes returned by a read |

## Verification
Scripted engine reply sequences drive each category up to its limit and one step short of it, so that the attempt at which the request stops shows which counter was charged. Sequences that mix categories separate the shared effects: a success that clears the timeout and invalid counters, a bus-side I2C defer that clears the defer count, and a timeout after a defer that is charged as a defer. Defer runs that differ only in delay and polling period separate the combined count-and-time exit from plain attempt exhaustion. Elapsed time from start to done is bounded around the expected sum of waits.

// File: rtl/auxr_pkg.sv
package auxr_pkg;
   localparam logic [2:0] RES_OK      = 3'd0;
   localparam logic [2:0] RES_TIMEOUT = 3'd1;
   localparam logic [2:0] RES_INVALID = 3'd2;
   localparam logic [2:0] RES_HPD     = 3'd3;
   localparam logic [2:0] RES_ACQ     = 3'd4;

   localparam logic [2:0] REP_ACK        = 3'd0;
   localparam logic [2:0] REP_NACK       = 3'd1;
   localparam logic [2:0] REP_DEFER      = 3'd2;
   localparam logic [2:0] REP_I2C_NACK   = 3'd3;
   localparam logic [2:0] REP_I2C_DEF_LK = 3'd4;
   localparam logic [2:0] REP_I2C_DEF_BS = 3'd5;
   localparam logic [2:0] REP_HPD        = 3'd6;

   localparam int CAT_SHORT = 0;
   localparam int CAT_DEFER = 1;
   localparam int CAT_I2CDF = 2;
   localparam int CAT_TMO   = 3;
   localparam int CAT_INV   = 4;
   localparam int NUM_CAT   = 5;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LAUNCH, ST_AWAIT, ST_EVAL, ST_PAUSE, ST_FINISH
   } auxr_state_e;
endpackage

// File: rtl/auxr_event_ctr.sv
module auxr_event_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr)              cnt <= '0;
      else if (inc && cnt != '1) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/auxr_defer_acc.sv
module auxr_defer_acc #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         add_en,
   input  logic [W-1:0] add_val,
   output logic [W-1:0] sum
);
   logic [W:0] nxt;
   assign nxt = {1'b0, sum} + {1'b0, add_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum <= '0;
      else if (clr)    sum <= '0;
      else if (add_en) sum <= nxt[W] ? '1 : nxt[W-1:0];
   end
endmodule

// File: rtl/auxr_us_wait.sv
module auxr_us_wait #(
   parameter int W        = 18,
   parameter bit TICK_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         us_tick,
   output logic         idle
);
   logic         tick_use;
   logic [W-1:0] remain;

   generate
      if (TICK_REG) begin : g_tick_reg
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= us_tick;
         end
         assign tick_use = tick_q;
      end else begin : g_tick_dir
         assign tick_use = us_tick;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         remain <= '0;
      else if (load)                      remain <= load_val;
      else if (tick_use && remain != '0)  remain <= remain - 1'b1;
   end

   assign idle = (remain == '0);
endmodule

// File: rtl/auxr_retry_ctrl.sv
module auxr_retry_ctrl
   import auxr_pkg::*;
#(
   parameter int LEN_W               = 8,
   parameter int DLY_W               = 8,
   parameter int MAX_ATTEMPTS        = 7,
   parameter int SHORT_LIMIT         = 7,
   parameter int DEFER_LIMIT         = 7,
   parameter int I2C_DEFER_LIMIT     = 7,
   parameter int INVALID_LIMIT       = 2,
   parameter int TIMEOUT_LIMIT       = 3,
   parameter int DEFER_TIME_LIMIT_MS = 50,
   parameter int SHORT_WAIT_US       = 300,
   parameter int INVALID_WAIT_US     = 400,
   parameter int US_PER_MS           = 1000,
   parameter bit TICK_REG            = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             us_tick,
   input  logic             req_start,
   input  logic             req_is_write,
   input  logic [LEN_W-1:0] req_len,
   input  logic [DLY_W-1:0] defer_delay_ms,
   input  logic [DLY_W-1:0] poll_period_ms,
   output logic             req_busy,
   output logic             req_done,
   output logic             req_pass,
   output logic             eng_start,
   input  logic             eng_done,
   input  logic [2:0]       eng_result,
   input  logic [2:0]       eng_reply,
   input  logic [LEN_W-1:0] eng_rd_count
);
   localparam int CNT_W  = $clog2(MAX_ATTEMPTS + 2);
   localparam int ATT_W  = $clog2(MAX_ATTEMPTS + 1);
   localparam int ACC_W  = DLY_W + 2;
   localparam int WAIT_W = $clog2(((2 ** DLY_W) - 1) * US_PER_MS
                                  + SHORT_WAIT_US + INVALID_WAIT_US + 1);

   generate
      if (MAX_ATTEMPTS < 1 || LEN_W < 1 || DLY_W < 1) begin : g_bad_size
         $error("auxr_retry_ctrl: sizes must be positive");
      end
      if (SHORT_LIMIT < 1 || DEFER_LIMIT < 1 || I2C_DEFER_LIMIT < 1 ||
          INVALID_LIMIT < 1 || TIMEOUT_LIMIT < 1) begin : g_bad_limit
         $error("auxr_retry_ctrl: retry limits must be at least one");
      end
      if (DEFER_TIME_LIMIT_MS >= 2 ** ACC_W) begin : g_bad_time
         $error("auxr_retry_ctrl: defer time limit exceeds accumulator range");
      end
   endgenerate

   auxr_state_e      state;
   logic             wr_q;
   logic [LEN_W-1:0] len_q;
   logic             seen_q;
   logic             pass_q;
   logic [ATT_W-1:0] att_q;
   logic [2:0]       res_q;
   logic [2:0]       rep_q;
   logic [LEN_W-1:0] cnt_q;

   logic             start_ok;
   assign start_ok = (state == ST_IDLE) && req_start;

   // per-category retry counters
   logic [NUM_CAT-1:0] ctr_inc;
   logic [NUM_CAT-1:0] ctr_evclr;
   logic [CNT_W-1:0]   ctr_val [NUM_CAT];

   generate
      for (genvar k = 0; k < NUM_CAT; k++) begin : g_ctr
         auxr_event_ctr #(.W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start_ok | ctr_evclr[k]),
            .inc   (ctr_inc[k]),
            .cnt   (ctr_val[k])
         );
      end
   endgenerate

   // accumulated defer time
   logic             acc_add;
   logic [ACC_W-1:0] acc_val;
   logic [ACC_W-1:0] acc_sum;

   auxr_defer_acc #(.W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start_ok),
      .add_en  (acc_add),
      .add_val (acc_val),
      .sum     (acc_sum)
   );

   // wait timer
   logic              wt_load;
   logic [WAIT_W-1:0] wt_val;
   logic              wt_idle;

   auxr_us_wait #(.W(WAIT_W), .TICK_REG(TICK_REG)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wt_load),
      .load_val (wt_val),
      .us_tick  (us_tick),
      .idle     (wt_idle)
   );

   // result classification
   logic [WAIT_W-1:0] delay_ticks;
   logic              is_native;
   logic              is_link;
   logic [ACC_W:0]    acc_eff;
   int                def_eff;
   logic              defer_exit;
   logic              dec_finish;
   logic              dec_pass;
   logic              dec_seen;
   logic              dec_dwait;

   assign delay_ticks = WAIT_W'(defer_delay_ms) * WAIT_W'(US_PER_MS);
   assign is_native   = (rep_q == REP_DEFER);
   assign is_link     = (rep_q == REP_I2C_DEF_LK);
   assign acc_eff     = {1'b0, acc_sum} + (is_native ? (ACC_W+1)'(poll_period_ms) : '0);
   assign def_eff     = int'(ctr_val[CAT_DEFER]) + (is_native ? 1 : 0);
   assign defer_exit  = (def_eff >= DEFER_LIMIT) && (int'(acc_eff) >= DEFER_TIME_LIMIT_MS);

   always_comb begin
      ctr_inc    = '0;
      ctr_evclr  = '0;
      dec_finish = 1'b0;
      dec_pass   = 1'b0;
      dec_seen   = 1'b0;
      dec_dwait  = 1'b0;
      wt_val     = '0;
      if (state == ST_EVAL) begin
         case (res_q)
            RES_OK: begin
               ctr_evclr[CAT_TMO] = 1'b1;
               ctr_evclr[CAT_INV] = 1'b1;
               case (rep_q)
                  REP_ACK: begin
                     if (wr_q || cnt_q == len_q) begin
                        dec_finish = 1'b1;
                        dec_pass   = 1'b1;
                     end else begin
                        ctr_inc[CAT_SHORT] = 1'b1;
                        if (int'(ctr_val[CAT_SHORT]) + 1 >= SHORT_LIMIT) dec_finish = 1'b1;
                        else wt_val = WAIT_W'(SHORT_WAIT_US);
                     end
                  end
                  REP_DEFER, REP_I2C_DEF_LK, REP_I2C_NACK: begin
                     ctr_inc[CAT_DEFER] = is_native;
                     dec_seen = is_native | is_link;
                     if (defer_exit) dec_finish = 1'b1;
                     else if (is_native || is_link) begin
                        dec_dwait = 1'b1;
                        wt_val    = delay_ticks;
                     end
                  end
                  REP_I2C_DEF_BS: begin
                     ctr_evclr[CAT_DEFER] = 1'b1;
                     ctr_inc[CAT_I2CDF]   = 1'b1;
                     if (int'(ctr_val[CAT_I2CDF]) + 1 >= I2C_DEFER_LIMIT) dec_finish = 1'b1;
                  end
                  default: dec_finish = 1'b1;
               endcase
            end
            RES_INVALID: begin
               ctr_inc[CAT_INV] = 1'b1;
               if (int'(ctr_val[CAT_INV]) + 1 >= INVALID_LIMIT) dec_finish = 1'b1;
               else wt_val = WAIT_W'(INVALID_WAIT_US);
            end
            RES_TIMEOUT: begin
               if (seen_q) begin
                  ctr_inc[CAT_DEFER] = 1'b1;
                  if (int'(ctr_val[CAT_DEFER]) + 1 >= DEFER_LIMIT) dec_finish = 1'b1;
                  else wt_val = delay_ticks;
               end else begin
                  ctr_inc[CAT_TMO] = 1'b1;
                  if (int'(ctr_val[CAT_TMO]) + 1 >= TIMEOUT_LIMIT) dec_finish = 1'b1;
               end
            end
            default: dec_finish = 1'b1;
         endcase
      end
   end

   assign acc_add = (state == ST_EVAL) && (res_q == RES_OK) && (is_native || dec_dwait);
   assign acc_val = (is_native ? ACC_W'(poll_period_ms) : '0)
                  + (dec_dwait ? ACC_W'(defer_delay_ms) : '0);
   assign wt_load = (state == ST_EVAL) && !dec_finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         wr_q   <= 1'b0;
         len_q  <= '0;
         seen_q <= 1'b0;
         pass_q <= 1'b0;
         att_q  <= '0;
         res_q  <= '0;
         rep_q  <= '0;
         cnt_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_start) begin
               wr_q   <= req_is_write;
               len_q  <= req_len;
               seen_q <= 1'b0;
               pass_q <= 1'b0;
               att_q  <= '0;
               state  <= ST_LAUNCH;
            end
            ST_LAUNCH: begin
               att_q <= att_q + 1'b1;
               state <= ST_AWAIT;
            end
            ST_AWAIT: if (eng_done) begin
               res_q <= eng_result;
               rep_q <= eng_reply;
               cnt_q <= eng_rd_count;
               state <= ST_EVAL;
            end
            ST_EVAL: begin
               if (dec_seen) seen_q <= 1'b1;
               if (dec_finish) begin
                  pass_q <= dec_pass;
                  state  <= ST_FINISH;
               end else begin
                  state <= ST_PAUSE;
               end
            end
            ST_PAUSE: if (wt_idle) begin
               if (int'(att_q) >= MAX_ATTEMPTS) state <= ST_FINISH;
               else                             state <= ST_LAUNCH;
            end
            ST_FINISH: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign eng_start = (state == ST_LAUNCH);
   assign req_busy  = (state != ST_IDLE);
   assign req_done  = (state == ST_FINISH);
   assign req_pass  = pass_q;
endmodule

// File: rtl/auxr_retry_chk.sv
module auxr_retry_chk
   import auxr_pkg::*;
#(
   parameter int MAX_ATTEMPTS = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_start,
   input logic       req_is_write,
   input logic       req_busy,
   input logic       req_done,
   input logic       req_pass,
   input logic       eng_start,
   input logic       eng_done,
   input logic [2:0] eng_result,
   input logic [2:0] eng_reply
);
   localparam int NW = $clog2(MAX_ATTEMPTS + 2) + 1;

   logic [NW-1:0] n_launch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     n_launch <= '0;
      else if (req_start && !req_busy) n_launch <= '0;
      else if (eng_start)              n_launch <= n_launch + 1'b1;
   end

   // R1: launches per request stay within the attempt budget
   a_r1_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
      int'(n_launch) <= MAX_ATTEMPTS);

   a_r12_launch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   a_r12_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> req_busy);

   a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> (!req_done && !req_busy));

   // R4: hot-plug loss ends the request in failure two cycles later
   a_r4_hpd_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (req_busy && eng_done && eng_result == RES_HPD) |-> ##2 (req_done && !req_pass));

   // R2: write acknowledged ends the request in pass two cycles later
   a_r2_write_ack_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_busy && eng_done && eng_result == RES_OK && eng_reply == REP_ACK && req_is_write)
      |-> ##2 (req_done && req_pass));
endmodule

bind auxr_retry_ctrl auxr_retry_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_start    (req_start),
   .req_is_write (req_is_write),
   .req_busy     (req_busy),
   .req_done     (req_done),
   .req_pass     (req_pass),
   .eng_start    (eng_start),
   .eng_done     (eng_done),
   .eng_result   (eng_result),
   .eng_reply    (eng_reply)
);

// File: tb/tb_auxr_retry_ctrl.sv
module tb_auxr_retry_ctrl;
   typedef struct packed {
      logic [2:0] res;
      logic [2:0] rep;
      logic [7:0] cnt;
   } rsp_t;

   typedef struct {
      bit    pass;
      int    att;
      int    wmin;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       us_tick = 1'b0;
   logic       req_start = 1'b0;
   logic       req_is_write = 1'b0;
   logic [7:0] req_len = '0;
   logic [7:0] defer_delay_ms = '0;
   logic [7:0] poll_period_ms = '0;
   logic       req_busy, req_done, req_pass, eng_start;
   logic       eng_done = 1'b0;
   logic [2:0] eng_result = '0;
   logic [2:0] eng_reply = '0;
   logic [7:0] eng_rd_count = '0;

   rsp_t rsp_q[$];
   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc = 0;
   int   start_cyc = 0;
   int   att_seen = 0;
   int   done_cnt = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   auxr_retry_ctrl #(.US_PER_MS(100), .DEFER_LIMIT(3)) dut (
      .clk (clk), .rst_n (rst_n), .us_tick (us_tick),
      .req_start (req_start), .req_is_write (req_is_write), .req_len (req_len),
      .defer_delay_ms (defer_delay_ms), .poll_period_ms (poll_period_ms),
      .req_busy (req_busy), .req_done (req_done), .req_pass (req_pass),
      .eng_start (eng_start), .eng_done (eng_done), .eng_result (eng_result),
      .eng_reply (eng_reply), .eng_rd_count (eng_rd_count)
   );

   task automatic chk(input string what, input bit ok, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, expv);
      end
   endtask

   // engine model: replays scripted responses, one per launch
   initial begin
      rsp_t r;
      forever begin
         @(negedge clk);
         if (eng_start) begin
            if (rsp_q.size() > 0) r = rsp_q.pop_front();
            else r = {3'd0, 3'd0, req_len};
            att_seen++;
            @(negedge clk);
            @(negedge clk);
            eng_done     = 1'b1;
            eng_result   = r.res;
            eng_reply    = r.rep;
            eng_rd_count = r.cnt;
            @(negedge clk);
            eng_done = 1'b0;
         end
      end
   end

   // monitor: compares each completion with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && req_done) begin
         exp_t e;
         int   el;
         el = cyc - start_cyc;
         if (exp_q.size() == 0) begin
            chk("unexpected completion R12", 1'b0, 1, 0);
         end else begin
            e = exp_q.pop_front();
            chk({e.tag, " pass"}, req_pass == e.pass, int'(req_pass), int'(e.pass));
            chk({e.tag, " attempts"}, att_seen == e.att, att_seen, e.att);
            chk({e.tag, " elapsed"}, el >= e.wmin && el <= e.wmin + e.att * 12 + 8,
                el, e.wmin);
         end
         done_cnt++;
      end
   end

   task automatic push(input logic [2:0] res, input logic [2:0] rep, input int cnt, input int n);
      for (int i = 0; i < n; i++) rsp_q.push_back({res, rep, 8'(cnt)});
   endtask

   task automatic run_case(input string tag, input bit wr, input int len, input int dly,
                           input int poll, input bit ep, input int eatt, input int wmin);
      exp_t e;
      int   tgt;
      e.tag = tag; e.pass = ep; e.att = eatt; e.wmin = wmin;
      exp_q.push_back(e);
      req_is_write   = wr;
      req_len        = 8'(len);
      defer_delay_ms = 8'(dly);
      poll_period_ms = 8'(poll);
      att_seen       = 0;
      tgt            = done_cnt + 1;
      @(negedge clk);
      req_start = 1'b1;
      start_cyc = cyc;
      @(negedge clk);
      req_start = 1'b0;
      wait (done_cnt >= tgt);
      @(negedge clk);
      rsp_q.delete();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected 0 cycles left", 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n   = 1'b1;
      us_tick = 1'b1;
      @(negedge clk);
      chk("R12 reset busy", req_busy == 1'b0, int'(req_busy), 0);
      chk("R12 reset done", req_done == 1'b0, int'(req_done), 0);
      chk("R12 reset eng_start", eng_start == 1'b0, int'(eng_start), 0);
      chk("R12 reset pass", req_pass == 1'b0, int'(req_pass), 0);

      // result: 0 ok 1 timeout 2 invalid 3 hpd 4 acquire; reply: 0 ack 1 nack 2 defer
      // 3 i2c nack 4 i2c defer link 5 i2c defer bus 6 hpd 7 unknown
      push(0, 0, 0, 1);  run_case("R2 write ack",           1, 4, 0, 0, 1, 1, 0);
      push(0, 0, 4, 1);  run_case("R2 full read ack",       0, 4, 0, 0, 1, 1, 0);
      push(0, 0, 2, 1); push(0, 0, 3, 1); push(0, 0, 4, 1);
      run_case("R3 short then full", 0, 4, 0, 0, 1, 3, 600);
      push(0, 0, 1, 7);  run_case("R3 short limit",         0, 4, 0, 0, 0, 7, 1800);
      push(0, 1, 0, 1);  run_case("R4 native nack",         1, 4, 0, 0, 0, 1, 0);
      push(3, 0, 0, 1);  run_case("R4 hpd result",          1, 4, 0, 0, 0, 1, 0);
      push(4, 0, 0, 1);  run_case("R4 acquire fail",        1, 4, 0, 0, 0, 1, 0);
      push(6, 0, 0, 1);  run_case("R4 unknown result",      1, 4, 0, 0, 0, 1, 0);
      push(0, 6, 0, 1);  run_case("R4 hpd reply",           1, 4, 0, 0, 0, 1, 0);
      push(0, 7, 0, 1);  run_case("R4 unknown reply",       1, 4, 0, 0, 0, 1, 0);
      push(2, 0, 0, 1); push(0, 0, 0, 1);
      run_case("R5 invalid once", 1, 4, 0, 0, 1, 2, 400);
      push(2, 0, 0, 2);  run_case("R5 invalid limit",       1, 4, 0, 0, 0, 2, 400);
      push(1, 0, 0, 2); push(0, 0, 0, 1);
      run_case("R6 timeout twice", 1, 4, 0, 0, 1, 3, 0);
      push(1, 0, 0, 3);  run_case("R6 timeout limit",       1, 4, 0, 0, 0, 3, 0);
      push(1, 0, 0, 2); push(0, 3, 0, 1); push(1, 0, 0, 2); push(0, 0, 0, 1);
      run_case("R7 success clears timeouts", 1, 4, 0, 0, 1, 6, 0);
      push(2, 0, 0, 1); push(0, 3, 0, 1); push(2, 0, 0, 1); push(0, 0, 0, 1);
      run_case("R7 success clears invalid", 1, 4, 0, 0, 1, 4, 800);
      push(0, 2, 0, 1); push(1, 0, 0, 2);
      run_case("R9 timeout after defer", 1, 4, 1, 5, 0, 3, 200);
      push(0, 4, 0, 1); push(1, 0, 0, 3);
      run_case("R9 link defer marks seen", 1, 4, 1, 0, 0, 4, 300);
      push(0, 2, 0, 7);  run_case("R8 count and time exit", 1, 4, 3, 5, 0, 7, 1800);
      push(0, 2, 0, 7);  run_case("R1 defer exhausts attempts", 1, 4, 1, 5, 0, 7, 700);
      push(0, 2, 0, 2); push(0, 5, 0, 1); push(0, 2, 0, 2); push(0, 0, 0, 1);
      run_case("R10 bus defer clears count", 1, 4, 0, 30, 1, 6, 0);
      push(0, 5, 0, 7);  run_case("R10 bus defer limit",    1, 4, 0, 0, 0, 7, 0);
      push(0, 3, 0, 7);  run_case("R11 i2c nack exhausts R1", 1, 4, 0, 0, 0, 7, 0);
      push(0, 2, 0, 3); push(0, 4, 0, 1); push(0, 3, 0, 1); push(0, 0, 0, 1);
      run_case("R11 nack applies exit rule", 1, 4, 10, 5, 0, 5, 4000);

      chk("R12 idle after run", req_busy == 1'b0, int'(req_busy), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule